// File: doc/BRIEF.md
# Add-Only EPROM Command Controller

This block is the memory-function layer of a one-time-programmable memory that talks over a single data wire. Bit timing and the wire-level reset/presence handshake live outside it. The block works on whole bytes. It receives bytes from the master on `rx_valid`/`rx_byte`. It returns one byte for each `tx_req` pulse. A separate strobe, `prog_pulse`, stands in for the high-voltage programming pulse. The storage is a register array of 128 bytes in four 32-byte pages. Beside it sits an 8-byte status field. In status byte 0, bit p cleared means page p is locked against programming.

A transaction opens with a command byte and a 16-bit target address, low byte first. Reads return a CRC of the header, then bytes up to the end of the selected field, then a CRC of the bytes returned, then 0xFF indefinitely. Write transactions work one byte at a time:
- the byte is parked in a scratchpad;
- the block returns a CRC for the master to compare;
- a program strobe ANDs the scratchpad into the array;
- a verify read returns the stored byte and advances the address.

The block never checks the CRC itself. Whether to strobe is the master's decision.

Top module: `add_only_mem_ctrl`

## Requirements
- R1: After `rst_n` is released, `tx_valid` is low, every array byte reads 0xFF, and every status byte reads 0xFF. Each `tx_req` pulse produces exactly one `tx_valid` pulse, one cycle later, with the reply on `tx_byte`.
- R2: Command 0xF0 followed by address bytes TA1 (low) and TA2 (high) works as follows. The first reply is a CRC over the command and both address bytes. The CRC is CRC-8 with polynomial x^8+x^5+x^4+1, data taken LSB first, zero seed. Each following reply is the array byte at the current offset, advancing by one, through offset 127.
- R3: After the last byte of a read field, the next reply is the CRC (zero seed) of the data bytes just returned. Every reply after that is 0xFF until `bus_reset`.
- R4: Command 0xAA reads the 8-byte status field with the same framing as R2 and R3, through offset 7.
- R5: Command 0x0F (array) or 0x55 (status field) takes address bytes and then a data byte. The data byte goes only into the scratchpad. The array is unchanged until a program strobe arrives.
- R6: For the first data byte of a write, the returned CRC covers the command, TA1, TA2 and the data byte. For each later data byte, the CRC is seeded to zero, fed the low 8 bits of the already advanced address, then fed the data byte.
- R7: A `prog_pulse` after the write CRC has been read sets the target byte to its old value AND the scratchpad. A bit at 0 never returns to 1.
- R8: The read after the write CRC (the verify) returns the stored byte. It then advances the address by one, whether or not a strobe came.
- R9: A strobe on a locked page (status byte 0, bit = page number, 0 = locked) leaves the array unchanged. The verify returns the old byte, and other pages stay writable.
- R10: `prog_pulse` is ignored outside the wait for program/verify. When `prog_pulse` and the verify `tx_req` fall in the same cycle, the verify returns the byte as programmed in that cycle.
- R11: `bus_reset` returns the block to waiting for a command from any state. Array contents are kept.
- R12: Address bits above the field width are ignored: the offset is TA modulo the field size. An unknown command byte yields 0xFF replies until `bus_reset`.
- R13: After the verify of the last byte of a field, a write transaction ignores further data bytes and replies 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; erases array and status field |
| bus_reset | input | 1 | Wire-level reset seen; abort transaction |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Byte from the master |
| tx_req | input | 1 | Master requests one byte |
| prog_pulse | input | 1 | Programming strobe |
| tx_valid | output | 1 | Reply byte valid (one cycle after `tx_req`) |
| tx_byte | output | 8 | Reply byte |

## Verification
The programming strobe and the verify read can arrive in the same cycle. The bench provokes this by raising `prog_pulse` and `tx_req` on one clock. The verify reply must already hold the old byte ANDed with the scratchpad, and the address must advance exactly once. A neighbouring case is a strobe that arrives outside the program wait, after an aborted write has left data in the scratchpad. The bench then reads the array back and expects it untouched.

// File: rtl/add_only_mem_ctrl.sv
module add_only_mem_ctrl #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  input  logic       prog_pulse,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  localparam int DATA_BYTES = PAGES * PAGE_BYTES;
  localparam int DA_W  = $clog2(DATA_BYTES);
  localparam int SA_W  = $clog2(STAT_BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = DA_W - OFF_W;

  typedef enum logic [3:0] {
    S_CMD, S_ALO, S_AHI, S_RCRC1, S_RDAT, S_RCRC2,
    S_WDAT, S_WCRC, S_WPROG, S_ONES
  } state_t;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  state_t      st;
  logic        to_stat, is_wr, first_w;
  logic [15:0] addr;
  logic [7:0]  sp, crc;
  logic [7:0]  mem  [DATA_BYTES];
  logic [7:0]  stat [STAT_BYTES];

  logic [DA_W-1:0] doff;
  logic [SA_W-1:0] soff;
  logic [PG_W-1:0] page;
  logic [7:0]      cur, wval, verify_val, txv, crc_base;
  logic            last, locked, prog_ok;
  logic            in_cmd, in_rcrc1, in_rdat, in_wprog, in_ones;

  assign doff   = addr[DA_W-1:0];
  assign soff   = addr[SA_W-1:0];
  assign page   = doff[DA_W-1:OFF_W];
  assign cur    = to_stat ? stat[soff] : mem[doff];
  assign last   = to_stat ? (soff == SA_W'(STAT_BYTES-1)) : (doff == DA_W'(DATA_BYTES-1));
  assign locked = !to_stat && !stat[0][page];

  assign in_cmd   = (st == S_CMD);
  assign in_rcrc1 = (st == S_RCRC1);
  assign in_rdat  = (st == S_RDAT);
  assign in_wprog = (st == S_WPROG);
  assign in_ones  = (st == S_ONES);

  assign prog_ok    = in_wprog && prog_pulse && !bus_reset;
  assign wval       = locked ? cur : (cur & sp);
  assign verify_val = prog_ok ? wval : cur;
  assign crc_base   = first_w ? crc : crc8(8'h00, addr[7:0]);

  always_comb begin
    case (st)
      S_RCRC1, S_RCRC2, S_WCRC: txv = crc;
      S_RDAT:                   txv = cur;
      S_WPROG:                  txv = verify_val;
      default:                  txv = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_CMD;
      to_stat  <= 1'b0;
      is_wr    <= 1'b0;
      first_w  <= 1'b0;
      addr     <= '0;
      sp       <= 8'hFF;
      crc      <= 8'h00;
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
      for (int i = 0; i < DATA_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < STAT_BYTES; i++) stat[i] <= 8'hFF;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= txv;
      if (prog_ok) begin
        if (to_stat) stat[soff] <= wval;
        else         mem[doff]  <= wval;
      end
      if (bus_reset) begin
        st <= S_CMD;
      end else begin
        case (st)
          S_CMD: if (rx_valid) begin
            crc <= crc8(8'h00, rx_byte);
            case (rx_byte)
              8'hF0: begin to_stat <= 1'b0; is_wr <= 1'b0; st <= S_ALO; end
              8'hAA: begin to_stat <= 1'b1; is_wr <= 1'b0; st <= S_ALO; end
              8'h0F: begin to_stat <= 1'b0; is_wr <= 1'b1; st <= S_ALO; end
              8'h55: begin to_stat <= 1'b1; is_wr <= 1'b1; st <= S_ALO; end
              default: st <= S_ONES;
            endcase
          end
          S_ALO: if (rx_valid) begin
            addr[7:0] <= rx_byte;
            crc       <= crc8(crc, rx_byte);
            st        <= S_AHI;
          end
          S_AHI: if (rx_valid) begin
            addr[15:8] <= rx_byte;
            crc        <= crc8(crc, rx_byte);
            first_w    <= 1'b1;
            st         <= is_wr ? S_WDAT : S_RCRC1;
          end
          S_RCRC1: if (tx_req) begin
            crc <= 8'h00;
            st  <= S_RDAT;
          end
          S_RDAT: if (tx_req) begin
            crc  <= crc8(crc, cur);
            addr <= addr + 16'd1;
            if (last) st <= S_RCRC2;
          end
          S_RCRC2: if (tx_req) st <= S_ONES;
          S_WDAT: if (rx_valid) begin
            sp      <= rx_byte;
            crc     <= crc8(crc_base, rx_byte);
            first_w <= 1'b0;
            st      <= S_WCRC;
          end
          S_WCRC: if (tx_req) st <= S_WPROG;
          S_WPROG: if (tx_req) begin
            addr <= addr + 16'd1;
            st   <= last ? S_ONES : S_WDAT;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module add_only_mem_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_reset,
  input logic        tx_req,
  input logic        prog_pulse,
  input logic        tx_valid,
  input logic [7:0]  tx_byte,
  input logic        in_cmd,
  input logic        in_wprog,
  input logic        in_ones,
  input logic        locked,
  input logic [7:0]  cur,
  input logic [15:0] addr
);
  a_r3_ones_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ones && tx_req && !bus_reset) |=> (tx_valid && tx_byte == 8'hFF));
  a_r7_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wprog && prog_pulse && !tx_req && !bus_reset) |=> ((cur & ~$past(cur)) == 8'h00));
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wprog && prog_pulse && locked && !tx_req && !bus_reset) |=> $stable(cur));
  a_r8_verify_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wprog && tx_req && !bus_reset) |=> (addr == $past(addr) + 16'd1));
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> in_cmd);
  a_r1_reply_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req) |=> !tx_valid);
endmodule

bind add_only_mem_ctrl add_only_mem_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .tx_req(tx_req),
  .prog_pulse(prog_pulse), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .in_cmd(in_cmd), .in_wprog(in_wprog), .in_ones(in_ones),
  .locked(locked), .cur(cur), .addr(addr)
);

// File: tb/add_only_mem_ctrl_tb.sv
module add_only_mem_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0, prog_pulse = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_valid;
  logic [7:0] tx_byte;

  int checks = 0, errors = 0;
  logic [7:0] q_exp [$];
  string      q_tag [$];

  logic [7:0] mm [128];
  logic [7:0] sm [8];
  logic [7:0] wcrc;
  logic [15:0] waddr;
  logic wfirst, wstat;

  always #(CLK_PERIOD/2) clk = ~clk;

  add_only_mem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    logic [7:0] x = d;
    repeat (8) begin
      logic mix;
      mix = r[0] ^ x[0];
      r = {1'b0, r[7:1]};
      x = {1'b0, x[7:1]};
      if (mix) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic note(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (q_exp.size() == 0) note(1'b0, "R1 unrequested reply", tx_byte, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        note(tx_byte == e, t, tx_byte, e);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    @(negedge clk); tx_req = 1'b1; q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic rd_prog(input logic [7:0] e, input string tag);
    @(negedge clk); tx_req = 1'b1; prog_pulse = 1'b1; q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk); tx_req = 1'b0; prog_pulse = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); prog_pulse = 1'b1;
    @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic read_field(input logic [7:0] cmd, input logic [15:0] ta, input string tag);
    logic [7:0] c;
    int n = (cmd == 8'hAA) ? 8 : 128;
    send(cmd); send(ta[7:0]); send(ta[15:8]);
    rd(bcrc(bcrc(bcrc(8'h00, cmd), ta[7:0]), ta[15:8]), {tag, " header crc"});
    c = 8'h00;
    for (int i = int'(ta) % n; i < n; i++) begin
      logic [7:0] v = (n == 8) ? sm[i] : mm[i];
      rd(v, {tag, " data"});
      c = bcrc(c, v);
    end
    rd(c, "R3 trailing crc");
    rd(8'hFF, "R3 ones after crc");
    rd(8'hFF, "R3 ones after crc");
    breset();
  endtask

  task automatic wstart(input logic [7:0] cmd, input logic [15:0] ta);
    send(cmd); send(ta[7:0]); send(ta[15:8]);
    wcrc = bcrc(bcrc(bcrc(8'h00, cmd), ta[7:0]), ta[15:8]);
    waddr = ta; wfirst = 1'b1; wstat = (cmd == 8'h55);
  endtask

  // mode 0: no strobe, 1: strobe then verify, 2: strobe with verify
  task automatic wdata(input logic [7:0] d, input int mode, input string tag);
    logic [7:0] c, old, nv;
    logic lk;
    c = wfirst ? bcrc(wcrc, d) : bcrc(bcrc(8'h00, waddr[7:0]), d);
    wfirst = 1'b0;
    send(d);
    rd(c, "R6 write crc");
    old = wstat ? sm[waddr[2:0]] : mm[waddr[6:0]];
    lk  = !wstat && !sm[0][waddr[6:5]];
    nv  = (mode != 0 && !lk) ? (old & d) : old;
    if (wstat) sm[waddr[2:0]] = nv; else mm[waddr[6:0]] = nv;
    if (mode == 1) begin strobe(); rd(nv, tag); end
    else if (mode == 2) rd_prog(nv, tag);
    else rd(nv, tag);
    waddr = waddr + 16'd1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
    for (int i = 0; i < 8; i++) sm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(tx_valid == 1'b0, "R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);

    read_field(8'hF0, 16'h0000, "R1 R2 erased array");
    read_field(8'hAA, 16'h0000, "R1 R4 erased status");

    // R5: data parked in scratchpad, aborted before strobe; R10 stray strobe
    wstart(8'h0F, 16'h0005);
    send(8'h5A);
    rd(bcrc(wcrc, 8'h5A), "R6 first crc");
    breset();
    strobe();
    read_field(8'hF0, 16'h0005, "R5 R10 array untouched");

    // R7/R8/R10 write sequence
    wstart(8'h0F, 16'h0005);
    wdata(8'h5A, 1, "R7 programmed verify");
    wdata(8'h3C, 0, "R8 verify without strobe");
    wdata(8'hF0, 2, "R10 strobe with verify");
    breset();
    wstart(8'h0F, 16'h0005);
    wdata(8'hF3, 1, "R7 add-only AND");
    breset();
    read_field(8'hF0, 16'h0105, "R12 R2 high address bits ignored");

    // R9 lock page 1
    wstart(8'h55, 16'h0000);
    wdata(8'hFD, 1, "R9 status programmed");
    breset();
    wstart(8'h0F, 16'h0020);
    wdata(8'h00, 1, "R9 locked page verify");
    wdata(8'h12, 2, "R9 locked page verify same cycle");
    breset();
    wstart(8'h0F, 16'h0040);
    wdata(8'h11, 1, "R9 unlocked page writable");
    breset();
    read_field(8'hAA, 16'h0000, "R4 status readback");
    read_field(8'hAA, 16'h0006, "R4 status tail");

    // R13 last byte of field
    wstart(8'h0F, 16'h007F);
    wdata(8'h77, 1, "R13 last byte verify");
    rd(8'hFF, "R13 ones after field end");
    send(8'h00);
    rd(8'hFF, "R13 data ignored after end");
    breset();

    // R12 unknown command, R11 abort mid-read keeps contents
    send(8'h33);
    rd(8'hFF, "R12 unknown command");
    breset();
    send(8'hF0); send(8'h00); send(8'h00);
    rd(bcrc(bcrc(bcrc(8'h00, 8'hF0), 8'h00), 8'h00), "R11 header before abort");
    rd(mm[0], "R11 data before abort");
    breset();
    read_field(8'hF0, 16'h0000, "R11 final array readback");

    repeat (4) @(negedge clk);
    note(q_exp.size() == 0, "R1 replies outstanding", 8'(q_exp.size()), 8'h00);
    finish_run();
  end
endmodule